// File: doc/BRIEF.md
# Voltage-Frequency Step Sequencer

The sequencer holds the operating point of a tiled compute array as a clock divider and a supply-voltage code. The tile clock is a 1600 MHz reference divided by an integer between 2 and 16, so it runs from 800 MHz (divider 2) down to 100 MHz (divider 16). A policy engine outside the block asks for one step faster or one step slower. The sequencer moves the divider by one, looks up the minimum voltage the new divider needs, and issues a series of register-write commands. Voltage commands go to each regulator island, and divider commands go to each tile.

The commands leave through a ready/valid port, one word per accepted transfer. The block orders them so that the supply never falls below what the running clock needs. On a speed-up, the islands are raised first, a programmable settling interval follows, and only then are the tiles re-clocked. On a slow-down, the tiles are re-clocked first and the islands are lowered afterwards. The minimum-voltage table has a small write port, one entry for each legal divider.

Top module: `vfs_step_sequencer`

## Requirements
- R1: After reset:
  - `busy` and `cmd_valid` are 0.
  - `cur_div` is 16 and `cur_vcode` is 208 (1.3 V in 6.25 mV units).
  - Every table entry reads 208.
- R2: A speed-up request lowers `cur_div` by one, and a slow-down request raises it by one. A speed-up at divider 2 or a slow-down at divider 16 is ignored: no command is issued and `busy` stays 0.
- R3: If the table entry for the new, smaller divider is above `cur_vcode`, the block first issues six voltage commands (islands 0 to 5, in ascending order) carrying that entry. It then holds `cmd_valid` low for `settle_cycles`+1 cycles, and only then issues divider commands.
- R4: Every step issues 24 divider commands, one for each tile 0 to 23 in ascending order, each carrying the new divider. `cmd_word[15:8]` holds the island or tile number and `cmd_word[7:0]` holds the value. `cmd_is_freq` is 1 for divider commands and 0 for voltage commands.
- R5: On a slow-down, all divider commands come first. They are followed by six voltage commands only if the table entry for the new divider is below `cur_vcode`, and those commands carry that entry.
- R6: A speed-up whose table entry is not above `cur_vcode` issues divider commands only, and `cur_vcode` is left unchanged.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_is_freq` and `cmd_word` hold their values.
- R8: `busy` rises in the cycle after a request is taken. It falls in the cycle after the last command of the sequence is accepted. Requests that arrive while `busy` is high have no effect.
- R9: When speed-up and slow-down are requested in the same cycle, the speed-up is performed and the slow-down is dropped.
- R10: A table write stores its value at the given divider index (2 to 16), clamped to the range 112 to 208. A write in the same cycle as an accepted request does not affect that request's lookup.
- R11: While the block is idle, `cur_div` and `cur_vcode` report the divider and voltage code most recently written to the tiles and islands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_up | input | 1 | Request one step faster (divider − 1) |
| step_down | input | 1 | Request one step slower (divider + 1) |
| settle_cycles | input | 16 | Extra idle cycles between raising voltage and raising frequency |
| tbl_wr_en | input | 1 | Write strobe for the minimum-voltage table |
| tbl_wr_idx | input | 5 | Divider index of the table entry to write |
| tbl_wr_vcode | input | 8 | Voltage code to store, in 6.25 mV units |
| cmd_valid | output | 1 | A command word is offered |
| cmd_ready | input | 1 | The receiver accepts the offered word |
| cmd_is_freq | output | 1 | 1 for a tile divider command, 0 for an island voltage command |
| cmd_word | output | 16 | Target number in [15:8], value in [7:0] |
| busy | output | 1 | A step sequence is in progress |
| cur_div | output | 5 | Divider currently applied |
| cur_vcode | output | 8 | Voltage code currently applied |

## Verification
Two things can land in the same cycle. A table write can coincide with the step request whose lookup reads that same entry. Separately, both request inputs can be raised together. The bench provokes the first by rewriting the entry for the next divider in the cycle a speed-up is taken, and judges it by the voltage words emitted and the final `cur_vcode`, both of which must show the old entry. It provokes the second by pulsing both requests at once and expects a sequence toward the smaller divider. Its queue model also checks, every cycle, that a request pulsed in the middle of a sequence under random back-pressure changes nothing.

// File: rtl/vfs_pkg.sv
// Package: shared phase type and helpers for the step sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package vfs_pkg;

    // Sequencer phases; VUP raises islands, VDN lowers them.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_VUP    = 3'd1,
        PH_SETTLE = 3'd2,
        PH_FREQ   = 3'd3,
        PH_VDN    = 3'd4
    } vfs_phase_e;

    // Larger of two widths, used to size the value field.
    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vfs_volt_table.sv
// Minimum-voltage table, one entry per legal divider.
// Writes are clamped to the usable voltage window; writes to an index
// outside the divider range are dropped. Reads of an out-of-range index
// return the window maximum. Assumes DIV_MIN <= DIV_MAX < 2**DIV_W.
module vfs_volt_table #(
    parameter int DIV_W     = 5,
    parameter int VCODE_W   = 8,
    parameter int DIV_MIN   = 2,
    parameter int DIV_MAX   = 16,
    parameter int VCODE_MIN = 112,
    parameter int VCODE_MAX = 208
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DIV_W-1:0]   wr_idx,
    input  logic [VCODE_W-1:0] wr_val,
    input  logic [DIV_W-1:0]   rd_idx,
    output logic [VCODE_W-1:0] rd_val
);
    localparam int DEPTH = DIV_MAX - DIV_MIN + 1;
    localparam logic [VCODE_W-1:0] V_LO = VCODE_W'(VCODE_MIN);
    localparam logic [VCODE_W-1:0] V_HI = VCODE_W'(VCODE_MAX);

    logic [VCODE_W-1:0] entry [DEPTH];
    logic [VCODE_W-1:0] wr_clamped;

    // Clamp the incoming code into the usable window.
    always_comb begin
        if (wr_val < V_LO)      wr_clamped = V_LO;
        else if (wr_val > V_HI) wr_clamped = V_HI;
        else                    wr_clamped = wr_val;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // One storage register per divider value; resets to the window top.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[g] <= V_HI;
            else if (wr_en && (wr_idx == DIV_W'(DIV_MIN + g)))
                entry[g] <= wr_clamped;
        end
    end

    // Combinational lookup by divider index.
    always_comb begin
        rd_val = V_HI;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == DIV_W'(DIV_MIN + i)) rd_val = entry[i];
        end
    end

    // R10: whatever is looked up stays inside the usable window.
    assert_entry_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_val >= V_LO) && (rd_val <= V_HI));

endmodule

// File: rtl/vfs_settle_timer.sv
// Down-counter that spaces the voltage rise from the frequency rise.
// Loaded with the settle count on the last voltage write; reports
// expiry once it has counted down to zero. Assumes load and run are
// never both high.
module vfs_settle_timer #(
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SETTLE_W-1:0] load_val,
    input  logic                run,
    output logic                expired
);
    logic [SETTLE_W-1:0] cnt;

    // Load, then count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && (cnt != '0))
            cnt <= cnt - SETTLE_W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/vfs_cmd_emitter.sv
// Walks the target index for one command burst and forms the word
// {target, value}. Islands are walked 0..NUM_ISLANDS-1 for voltage and
// tiles 0..NUM_TILES-1 for dividers. The index wraps to 0 when the last
// word is accepted. Assumes the selection does not change mid-burst.
module vfs_cmd_emitter #(
    parameter int ID_W        = 8,
    parameter int VAL_W       = 8,
    parameter int NUM_ISLANDS = 6,
    parameter int NUM_TILES   = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic                  is_freq,
    input  logic [VAL_W-1:0]      value,
    output logic [ID_W+VAL_W-1:0] word,
    output logic                  last
);
    logic [ID_W-1:0] idx;
    logic [ID_W-1:0] idx_end;

    // Last index of the current burst.
    assign idx_end = is_freq ? ID_W'(NUM_TILES - 1) : ID_W'(NUM_ISLANDS - 1);
    assign last    = (idx == idx_end);
    assign word    = {idx, value};

    // Advance on every accepted word, wrap after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (fire)
            idx <= last ? '0 : idx + ID_W'(1);
    end

    // R4: the target index never runs past its burst.
    assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= ID_W'(NUM_TILES - 1));

endmodule

// File: rtl/vfs_step_sequencer.sv
// Top level: takes single-step speed requests and turns each one into an
// ordered burst of island-voltage and tile-divider commands. Voltage
// rises before a faster clock and falls after a slower one.
// Assumes the command receiver eventually raises cmd_ready.
module vfs_step_sequencer
    import vfs_pkg::*;
#(
    parameter int NUM_ISLANDS      = 6,
    parameter int TILES_PER_ISLAND = 4,
    parameter int DIV_W            = 5,
    parameter int DIV_MIN          = 2,
    parameter int DIV_MAX          = 16,
    parameter int VCODE_W          = 8,
    parameter int VCODE_MIN        = 112,
    parameter int VCODE_MAX        = 208,
    parameter int ID_W             = 8,
    parameter int SETTLE_W         = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step_up,
    input  logic                        step_down,
    input  logic [SETTLE_W-1:0]         settle_cycles,
    input  logic                        tbl_wr_en,
    input  logic [DIV_W-1:0]            tbl_wr_idx,
    input  logic [VCODE_W-1:0]          tbl_wr_vcode,
    output logic                        cmd_valid,
    input  logic                        cmd_ready,
    output logic                        cmd_is_freq,
    output logic [ID_W+max_w(VCODE_W, DIV_W)-1:0] cmd_word,
    output logic                        busy,
    output logic [DIV_W-1:0]            cur_div,
    output logic [VCODE_W-1:0]          cur_vcode
);
    localparam int NUM_TILES = NUM_ISLANDS * TILES_PER_ISLAND;
    localparam int VAL_W     = max_w(VCODE_W, DIV_W);
    localparam logic [DIV_W-1:0] D_LO = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] D_HI = DIV_W'(DIV_MAX);

    vfs_phase_e         phase;
    logic [DIV_W-1:0]   tgt_div;
    logic [VCODE_W-1:0] tgt_v;
    logic [VCODE_W-1:0] need_lat;
    logic               lower_pend;
    logic [DIV_W-1:0]   rd_idx;
    logic [VCODE_W-1:0] need;
    logic               accept_up;
    logic               accept_dn;
    logic               fire;
    logic               last;
    logic               settle_done;
    logic [VAL_W-1:0]   cmd_value;

    // Look up the divider the request would move to.
    assign rd_idx    = step_up ? (cur_div - DIV_W'(1)) : (cur_div + DIV_W'(1));
    // A request is taken only when idle and inside the divider range; up wins.
    assign accept_up = (phase == PH_IDLE) && step_up && (cur_div != D_LO);
    assign accept_dn = (phase == PH_IDLE) && !step_up && step_down && (cur_div != D_HI);

    assign busy        = (phase != PH_IDLE);
    assign cmd_valid   = (phase == PH_VUP) || (phase == PH_FREQ) || (phase == PH_VDN);
    assign cmd_is_freq = (phase == PH_FREQ);
    assign cmd_value   = cmd_is_freq ? VAL_W'(tgt_div) : VAL_W'(tgt_v);
    assign fire        = cmd_valid && cmd_ready;

    vfs_volt_table #(
        .DIV_W    (DIV_W),
        .VCODE_W  (VCODE_W),
        .DIV_MIN  (DIV_MIN),
        .DIV_MAX  (DIV_MAX),
        .VCODE_MIN(VCODE_MIN),
        .VCODE_MAX(VCODE_MAX)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (tbl_wr_en),
        .wr_idx(tbl_wr_idx),
        .wr_val(tbl_wr_vcode),
        .rd_idx(rd_idx),
        .rd_val(need)
    );

    vfs_settle_timer #(
        .SETTLE_W(SETTLE_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((phase == PH_VUP) && fire && last),
        .load_val(settle_cycles),
        .run     (phase == PH_SETTLE),
        .expired (settle_done)
    );

    vfs_cmd_emitter #(
        .ID_W       (ID_W),
        .VAL_W      (VAL_W),
        .NUM_ISLANDS(NUM_ISLANDS),
        .NUM_TILES  (NUM_TILES)
    ) u_emit (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .is_freq(cmd_is_freq),
        .value  (cmd_value),
        .word   (cmd_word),
        .last   (last)
    );

    // Step sequencing and the committed operating point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            tgt_div    <= D_HI;
            tgt_v      <= VCODE_W'(VCODE_MAX);
            need_lat   <= VCODE_W'(VCODE_MAX);
            lower_pend <= 1'b0;
            cur_div    <= D_HI;
            cur_vcode  <= VCODE_W'(VCODE_MAX);
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept_up) begin
                        tgt_div    <= cur_div - DIV_W'(1);
                        need_lat   <= need;
                        lower_pend <= 1'b0;
                        if (need > cur_vcode) begin
                            tgt_v <= need;
                            phase <= PH_VUP;
                        end else begin
                            tgt_v <= cur_vcode;
                            phase <= PH_FREQ;
                        end
                    end else if (accept_dn) begin
                        tgt_div    <= cur_div + DIV_W'(1);
                        need_lat   <= need;
                        lower_pend <= (need < cur_vcode);
                        tgt_v      <= (need < cur_vcode) ? need : cur_vcode;
                        phase      <= PH_FREQ;
                    end
                end
                PH_VUP: begin
                    if (fire && last) begin
                        cur_vcode <= tgt_v;
                        phase     <= PH_SETTLE;
                    end
                end
                PH_SETTLE: begin
                    if (settle_done) phase <= PH_FREQ;
                end
                PH_FREQ: begin
                    if (fire && last) begin
                        cur_div <= tgt_div;
                        phase   <= lower_pend ? PH_VDN : PH_IDLE;
                    end
                end
                PH_VDN: begin
                    if (fire && last) begin
                        cur_vcode <= tgt_v;
                        phase     <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R7: an offered word is held until it is taken.
    assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_word) && $stable(cmd_is_freq)));

    // R2: the applied divider never leaves its legal range.
    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_div >= D_LO) && (cur_div <= D_HI));

    // R3: a faster divider is only offered once the supply already covers it.
    assert_volt_before_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_freq && (tgt_div < cur_div)) |-> (cur_vcode >= need_lat));

    // R5: islands are lowered only after every tile took the slower divider.
    assert_freq_before_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_VDN) |-> (cur_div == tgt_div));

    // R8: busy falls only right after an accepted word.
    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cmd_valid && cmd_ready));

    // R8: requests seen while busy leave the target alone.
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(tgt_div)));

endmodule

// File: tb/vfs_step_sequencer_bench.sv
// Bench: a queue-based reference model predicts the command stream and
// the busy flag and is compared every clock; directed scenarios add
// explicit checks on the committed operating point.
module vfs_step_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_up, step_down;
    logic [15:0] settle_cycles;
    logic        tbl_wr_en;
    logic [4:0]  tbl_wr_idx;
    logic [7:0]  tbl_wr_vcode;
    logic        cmd_valid, cmd_ready, cmd_is_freq;
    logic [15:0] cmd_word;
    logic        busy;
    logic [4:0]  cur_div;
    logic [7:0]  cur_vcode;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit ready_rand = 0;
    int lfsr = 32'h1ACE5;

    // Reference model state.
    int m_div, m_v;
    int m_tbl [32];
    int exp_q [$];

    always #4 clk = ~clk;

    vfs_step_sequencer u_vfs_step_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_up      (step_up),
        .step_down    (step_down),
        .settle_cycles(settle_cycles),
        .tbl_wr_en    (tbl_wr_en),
        .tbl_wr_idx   (tbl_wr_idx),
        .tbl_wr_vcode (tbl_wr_vcode),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_is_freq  (cmd_is_freq),
        .cmd_word     (cmd_word),
        .busy         (busy),
        .cur_div      (cur_div),
        .cur_vcode    (cur_vcode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tbl_target(input int d);
        int v = 112 + (16 - d) * 7;
        return (v > 208) ? 208 : v;
    endfunction

    // Build the expected command stream for one accepted request.
    task automatic model_request(input bit up, input bit dn);
        int nd, nv;
        if (up) begin
            if (m_div == 2) return;
            nd = m_div - 1;
            nv = m_tbl[nd];
            if (nv > m_v) begin
                for (int i = 0; i < 6; i++) exp_q.push_back((i << 8) | nv);
                for (int i = 0; i <= int'(settle_cycles); i++) exp_q.push_back(-1);
                m_v = nv;
            end
            for (int t = 0; t < 24; t++) exp_q.push_back(32'h10000 | (t << 8) | nd);
            m_div = nd;
        end else if (dn) begin
            if (m_div == 16) return;
            nd = m_div + 1;
            nv = m_tbl[nd];
            for (int t = 0; t < 24; t++) exp_q.push_back(32'h10000 | (t << 8) | nd);
            if (nv < m_v) begin
                for (int i = 0; i < 6; i++) exp_q.push_back((i << 8) | nv);
                m_v = nv;
            end
            m_div = nd;
        end
    endtask

    // Random back-pressure on the command port.
    always @(posedge clk) begin
        lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        cmd_ready <= ready_rand ? lfsr[3] : 1'b1;
    end

    // Per-cycle comparison and model advance, away from the active edge.
    always @(negedge clk) begin
        bit was_idle;
        int head, act;
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
        if (!rst_n) begin
            m_div = 16;
            m_v   = 208;
            for (int i = 0; i < 32; i++) m_tbl[i] = 208;
            exp_q.delete();
        end else begin
            was_idle = (exp_q.size() == 0);
            chk(busy == !was_idle, "R8 busy", busy, !was_idle);
            if (was_idle) begin
                chk(!cmd_valid, "R8 idle valid", cmd_valid, 0);
                chk(int'(cur_div) == m_div, "R11 cur_div", cur_div, m_div);
                chk(int'(cur_vcode) == m_v, "R11 cur_vcode", cur_vcode, m_v);
            end else begin
                head = exp_q[0];
                if (head < 0) begin
                    chk(!cmd_valid, "R3 settle gap", cmd_valid, 0);
                    void'(exp_q.pop_front());
                end else begin
                    act = {15'd0, cmd_is_freq, cmd_word};
                    chk(cmd_valid && act == head, "R3/R4/R5 command", act, head);
                    if (cmd_ready) void'(exp_q.pop_front());
                end
            end
            if (was_idle) model_request(step_up, step_down);
            if (tbl_wr_en && tbl_wr_idx >= 2 && tbl_wr_idx <= 16)
                m_tbl[tbl_wr_idx] = (tbl_wr_vcode < 112) ? 112 :
                                    (tbl_wr_vcode > 208) ? 208 : int'(tbl_wr_vcode);
        end
    end

    task automatic pulse(input bit up, input bit dn, input bit we, input int idx, input int val);
        @(posedge clk); #1;
        step_up = up; step_down = dn;
        tbl_wr_en = we; tbl_wr_idx = 5'(idx); tbl_wr_vcode = 8'(val);
        @(posedge clk); #1;
        step_up = 0; step_down = 0; tbl_wr_en = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; step_up = 0; step_down = 0; settle_cycles = 16'd0;
        tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_vcode = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!busy && !cmd_valid, "R1 reset idle", busy, 0);
        chk(cur_div == 5'd16, "R1 reset divider", cur_div, 16);
        chk(cur_vcode == 8'd208, "R1 reset vcode", cur_vcode, 208);

        // R6 and R1: table still at 208, so no voltage writes.
        pulse(1, 0, 0, 0, 0); wait_idle();
        chk(cur_div == 5'd15, "R6 divider", cur_div, 15);
        chk(cur_vcode == 8'd208, "R6 vcode kept", cur_vcode, 208);

        // R10: program the table, index 16 below the window.
        for (int d = 2; d <= 16; d++) pulse(0, 0, 1, d, (d == 16) ? 90 : tbl_target(d));

        // R5: slow down lowers the islands after the tiles.
        pulse(0, 1, 0, 0, 0); wait_idle();
        chk(cur_div == 5'd16, "R5 divider", cur_div, 16);
        chk(cur_vcode == 8'd112, "R5/R10 clamped vcode", cur_vcode, 112);

        // R3 with settle and back-pressure.
        ready_rand = 1; settle_cycles = 16'd3;
        pulse(1, 0, 0, 0, 0); wait_idle();
        chk(cur_vcode == 8'(tbl_target(15)), "R3 vcode", cur_vcode, tbl_target(15));

        // R8: slow-down mid-sequence is ignored.
        pulse(1, 0, 0, 0, 0);
        repeat (5) @(posedge clk);
        pulse(0, 1, 0, 0, 0); wait_idle();
        chk(cur_div == 5'd14, "R8 ignored while busy", cur_div, 14);

        // R9: both requests together.
        pulse(1, 1, 0, 0, 0); wait_idle();
        chk(cur_div == 5'd13, "R9 up wins", cur_div, 13);

        // R10: table write in the cycle of the request uses the old entry.
        pulse(1, 0, 1, 12, 208); wait_idle();
        chk(cur_vcode == 8'(tbl_target(12)), "R10 same-cycle old entry", cur_vcode, tbl_target(12));

        // R2: run to the fast bound, then one more is ignored.
        settle_cycles = 16'd0;
        for (int i = 0; i < 10; i++) begin pulse(1, 0, 0, 0, 0); wait_idle(); end
        chk(cur_div == 5'd2, "R2 fast bound", cur_div, 2);
        chk(cur_vcode == 8'd208, "R10 clamp top", cur_vcode, 208);
        pulse(1, 0, 0, 0, 0);
        @(negedge clk);
        chk(!busy && !cmd_valid, "R2 ignored at divider 2", busy, 0);

        // R2/R5: back down to the slow bound.
        for (int i = 0; i < 14; i++) begin pulse(0, 1, 0, 0, 0); wait_idle(); end
        chk(cur_div == 5'd16, "R2 slow bound", cur_div, 16);
        chk(cur_vcode == 8'd112, "R5 vcode at slow bound", cur_vcode, 112);
        pulse(0, 1, 0, 0, 0);
        @(negedge clk);
        chk(!busy && !cmd_valid, "R2 ignored at divider 16", busy, 0);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule